// File: doc/BRIEF.md
# Quad SPI Command Phase Sequencer

This block runs one serial-flash transaction at a time. Three 16-bit command words set the shape of a transaction: a 0- or 1-byte command, an address of up to four bytes, a run of dummy bytes, and then either write data or read data. Each phase has its own lane width, which may be one, two or four data lines. Every byte that goes out is pulled from a transmit byte stream. This covers the opcode, the address, the dummy filler and any write data. Bytes captured during a read phase are pushed onto a receive byte stream.

The block does not divide the clock. A one-cycle `sck_tick` input paces the serial side, and each tick that the sequencer accepts moves one lane-group of bits. The block answers each accepted tick with a one-cycle `sclk_pulse`, which the pad logic turns into a serial clock edge pair. Chip select is held low while bytes are being moved. `busy` covers the whole run, from start to completion.

Top module: `qspi_phase_seq`

## Requirements
- R1: After reset, `cs_n` is 1 and `busy`, `io_oe`, `sclk_pulse`, `rx_valid` and `tx_ready` are all 0.
- R2: A transaction starts only when the valid flag (bit 15 of command word 0) and `ctrl_en` are both 1. If the flag is set while `ctrl_en` is 0, the block stays idle and takes nothing from the transmit stream. Raising `ctrl_en` afterwards starts the transaction.
- R3: Phase order is command (count in word0 bit 0), address, dummy (count in word1 bits 3:0), write data (count in word0 bits 14:4). The block pops exactly that many bytes from the transmit stream, in order, and shifts each popped byte out once.
- R4: The address byte count is word0 bits 2:1. With that field equal to 3 and word0 bit 3 set, four address bytes are sent. Bit 3 has no effect for any other address count.
- R5: Lane codes are taken from word2: bits 1:0 for the command, bits 3:2 for the address and the dummy bytes, and bits 5:4 for data. Code 3 selects four lanes: `io_oe`=1111, 2 clocks per byte. Code 2 selects two lanes: `io_oe`=0011, 4 clocks. Codes 1 and 0 select one lane: `io_oe`=0001, 8 clocks.
- R6: Bytes go out MSB first. A single lane uses `io_out[0]`. With two lanes, `io_out[1]` carries the more significant bit of each pair. With four lanes, `io_out[3]` carries the most significant bit of each nibble.
- R7: In a read phase (count in word1 bits 14:4), `io_oe` is 0. Data is sampled on `io_in[1]` for one lane, `io_in[1:0]` for two lanes and `io_in[3:0]` for four lanes, MSB first, and one byte is pushed on `rx_data` with a one-cycle `rx_valid`.
- R8: When the write count and the read count are both nonzero, the write data is sent and the read count is ignored: nothing is pushed to the receive stream.
- R9: `cs_n` is low only while `busy` is high. Every `sclk_pulse` follows a cycle with `cs_n` low. After completion the valid flag clears itself, so the transaction does not restart while `ctrl_en` stays high.
- R10: While the block waits for a transmit byte (`tx_ready` high, `tx_valid` low), no serial clock pulse follows. It resumes when the byte arrives.
- R11: A valid transaction with all counts zero raises `busy` briefly and completes with no clock pulse and without lowering `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable; gates the start |
| reg_we | input | 1 | Command word write strobe |
| reg_sel | input | 2 | Command word index (0, 1, 2) |
| reg_wdata | input | 16 | Command word write value |
| sck_tick | input | 1 | Serial clock pacing tick |
| tx_data | input | 8 | Transmit stream byte |
| tx_valid | input | 1 | Transmit stream byte present |
| tx_ready | output | 1 | Block takes the transmit byte when valid |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle push of `rx_data` |
| io_in | input | 4 | Data lines from the flash |
| io_out | output | 4 | Data lines to the flash |
| io_oe | output | 4 | Per-line output enable |
| sclk_pulse | output | 1 | One-cycle serial clock enable per transferred lane-group |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Transaction in progress |

## Verification
Each random transaction draws every phase count and every lane code independently. This separates per-phase width selection from a single shared width, and makes the dummy phase's use of the address width visible against the data width. Directed cases isolate specific behaviours:
- The enable gating, by setting the valid flag first and raising `ctrl_en` later.
- The extra-address flag, once with an address count of 3 and once with 2.
- The choice of write over read when both counts are set.
- A transaction with all counts zero.
- A quad write with gaps in the transmit stream, which separates stall handling from a block that keeps clocking out stale bytes.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_WR    = 3'd3,
    PH_RD    = 3'd4,
    PH_NONE  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SHIFT,
    ST_DONE
  } state_e;

  localparam int NUM_PHASES = 5;

  // lane code -> number of active lines (0 and 1 both mean one line)
  function automatic logic [2:0] lane_count(input logic [1:0] code);
    case (code)
      2'd3:    return 3'd4;
      2'd2:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] units_per_byte(input logic [2:0] lanes);
    case (lanes)
      3'd4:    return 4'd2;
      3'd2:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] oe_mask(input logic [2:0] lanes);
    case (lanes)
      3'd4:    return 4'b1111;
      3'd2:    return 4'b0011;
      default: return 4'b0001;
    endcase
  endfunction

  // top bits of the shift register placed on the low lines
  function automatic logic [3:0] drive_bits(input logic [7:0] sh, input logic [2:0] lanes);
    case (lanes)
      3'd4:    return sh[7:4];
      3'd2:    return {2'b00, sh[7:6]};
      default: return {3'b000, sh[7]};
    endcase
  endfunction

  // shift left by the lane count, filling with sampled input lines
  function automatic logic [7:0] shift_in(input logic [7:0] sh, input logic [2:0] lanes,
                                          input logic [3:0] pins);
    case (lanes)
      3'd4:    return {sh[3:0], pins};
      3'd2:    return {sh[5:0], pins[1:0]};
      default: return {sh[6:0], pins[1]};
    endcase
  endfunction

endpackage

// File: rtl/qspi_cmd_regs.sv
module qspi_cmd_regs #(
  parameter int REG_W     = 16,
  parameter int NUM_REGS  = 3,
  parameter int SEL_W     = 2,
  parameter int VALID_BIT = 15
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [SEL_W-1:0]                sel,
  input  logic [REG_W-1:0]                wdata,
  input  logic                            clr_valid,
  output logic [NUM_REGS-1:0][REG_W-1:0]  words
);

  logic [REG_W-1:0] store [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store[g] <= '0;
      end else begin
        if (we && sel == SEL_W'(g)) store[g] <= wdata;
        // completion clears the start flag; it wins over a same-cycle write
        if (g == 0 && clr_valid) store[g][VALID_BIT] <= 1'b0;
      end
    end
    assign words[g] = store[g];
  end

  assert_valid_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> !words[0][VALID_BIT]);

endmodule

// File: rtl/qspi_phase_ctrl.sv
module qspi_phase_ctrl
  import qspi_seq_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_req,
  input  logic [NUM_PHASES-1:0][CNT_W-1:0]  phase_len,
  input  logic [NUM_PHASES-1:0][2:0]        phase_lanes,
  input  logic                              tx_valid,
  input  logic                              tick,
  input  logic                              last_unit,
  output logic                              tx_ready,
  output logic                              ld,
  output logic                              ld_rx,
  output logic [2:0]                        ld_lanes,
  output logic                              step,
  output logic                              busy,
  output logic                              cs_n,
  output logic                              done
);

  state_e            state;
  phase_e            phase;
  logic [CNT_W-1:0]  left;
  phase_e            first_ph;
  phase_e            next_ph;
  logic              byte_end;

  function automatic phase_e first_nonzero(input logic [2:0] from,
                                           input logic [NUM_PHASES-1:0][CNT_W-1:0] lens);
    phase_e res;
    res = PH_NONE;
    for (int i = NUM_PHASES - 1; i >= 0; i--) begin
      if (i >= int'(from) && lens[i] != '0) res = phase_e'(3'(i));
    end
    return res;
  endfunction

  assign first_ph = first_nonzero(3'd0, phase_len);
  assign next_ph  = first_nonzero(3'(phase) + 3'd1, phase_len);

  assign tx_ready = (state == ST_FETCH) && (phase != PH_RD);
  assign ld       = (state == ST_FETCH) && ((phase == PH_RD) || tx_valid);
  assign ld_rx    = (phase == PH_RD);
  assign ld_lanes = (phase == PH_NONE) ? 3'd1 : phase_lanes[phase];
  assign step     = (state == ST_SHIFT) && tick;
  assign byte_end = step && last_unit;
  assign busy     = (state != ST_IDLE);
  assign cs_n     = !((state == ST_FETCH) || (state == ST_SHIFT));
  assign done     = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= PH_NONE;
      left  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            if (first_ph == PH_NONE) begin
              state <= ST_DONE;
            end else begin
              phase <= first_ph;
              left  <= phase_len[first_ph];
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (ld) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (byte_end) begin
            if (left > CNT_W'(1)) begin
              left  <= left - CNT_W'(1);
              state <= ST_FETCH;
            end else if (next_ph == PH_NONE) begin
              phase <= PH_NONE;
              state <= ST_DONE;
            end else begin
              phase <= next_ph;
              left  <= phase_len[next_ph];
              state <= ST_FETCH;
            end
          end
        end
        default: begin
          phase <= PH_NONE;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));

  assert_cs_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

endmodule

// File: rtl/qspi_lane_shifter.sv
module qspi_lane_shifter
  import qspi_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PINS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              ld_rx,
  input  logic [2:0]        ld_lanes,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              step,
  input  logic              flush,
  input  logic [PINS-1:0]   io_in,
  output logic [PINS-1:0]   io_out,
  output logic [PINS-1:0]   io_oe,
  output logic              sclk_pulse,
  output logic              last_unit,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid
);

  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] sh_next;
  logic [3:0]        units;
  logic [2:0]        lanes;
  logic              rx_mode;

  assign last_unit = (units == 4'd1);
  assign sh_next   = shift_in(sh, lanes, io_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      units      <= '0;
      lanes      <= 3'd1;
      rx_mode    <= 1'b0;
      io_out     <= '0;
      io_oe      <= '0;
      sclk_pulse <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
    end else begin
      sclk_pulse <= 1'b0;
      rx_valid   <= 1'b0;
      if (ld) begin
        sh      <= ld_rx ? '0 : ld_byte;
        units   <= units_per_byte(ld_lanes);
        lanes   <= ld_lanes;
        rx_mode <= ld_rx;
      end else if (step) begin
        sh         <= sh_next;
        units      <= units - 4'd1;
        sclk_pulse <= 1'b1;
        if (rx_mode) begin
          io_out <= '0;
          io_oe  <= '0;
          if (last_unit) begin
            rx_data  <= sh_next;
            rx_valid <= 1'b1;
          end
        end else begin
          io_out <= drive_bits(sh, lanes);
          io_oe  <= oe_mask(lanes);
        end
      end else if (flush) begin
        io_out <= '0;
        io_oe  <= '0;
      end
    end
  end

  assert_rx_lines_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (io_oe == '0));

  assert_oe_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

endmodule

// File: rtl/qspi_phase_seq.sv
module qspi_phase_seq
  import qspi_seq_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int DATA_CNT_W  = 11,
  parameter int DUMMY_CNT_W = 4,
  parameter int SEL_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             sck_tick,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic [3:0]       io_in,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic             sclk_pulse,
  output logic             cs_n,
  output logic             busy
);

  localparam int CNT_W     = DATA_CNT_W;
  localparam int NUM_WORDS = 3;
  localparam int VALID_BIT = REG_W - 1;
  localparam int DATA_LSB  = 4;
  localparam int DATA_MSB  = DATA_LSB + DATA_CNT_W - 1;

  logic [NUM_WORDS-1:0][REG_W-1:0]        words;
  logic [REG_W-1:0]                       w0, w1, w2;
  logic [NUM_PHASES-1:0][CNT_W-1:0]       phase_len;
  logic [NUM_PHASES-1:0][2:0]             phase_lanes;
  logic [CNT_W-1:0]                       wr_len;
  logic [CNT_W-1:0]                       rd_req;
  logic [2:0]                             addr_len;
  logic                                   start_req;
  logic                                   done;
  logic                                   ld, ld_rx, step, last_unit;
  logic [2:0]                             ld_lanes;
  logic                                   unused_bits;

  qspi_cmd_regs #(
    .REG_W(REG_W), .NUM_REGS(NUM_WORDS), .SEL_W(SEL_W), .VALID_BIT(VALID_BIT)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .clr_valid(done), .words(words)
  );

  assign w0 = words[0];
  assign w1 = words[1];
  assign w2 = words[2];

  // field decode: four address bytes only with count 3 plus the extra flag
  assign addr_len  = {1'b0, w0[2:1]} + {2'b00, (w0[3] && (w0[2:1] == 2'd3))};
  assign wr_len    = w0[DATA_MSB:DATA_LSB];
  assign rd_req    = w1[DATA_MSB:DATA_LSB];
  assign start_req = w0[VALID_BIT] && ctrl_en;

  assign phase_len[PH_CMD]   = CNT_W'(w0[0]);
  assign phase_len[PH_ADDR]  = CNT_W'(addr_len);
  assign phase_len[PH_DUMMY] = CNT_W'(w1[DUMMY_CNT_W-1:0]);
  assign phase_len[PH_WR]    = wr_len;
  assign phase_len[PH_RD]    = (wr_len != '0) ? '0 : rd_req;

  assign phase_lanes[PH_CMD]   = lane_count(w2[1:0]);
  assign phase_lanes[PH_ADDR]  = lane_count(w2[3:2]);
  assign phase_lanes[PH_DUMMY] = lane_count(w2[3:2]);
  assign phase_lanes[PH_WR]    = lane_count(w2[5:4]);
  assign phase_lanes[PH_RD]    = lane_count(w2[5:4]);

  assign unused_bits = ^{w1[REG_W-1], w1[DATA_LSB-1:DUMMY_CNT_W], w2[REG_W-1:6]};

  qspi_phase_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .phase_len(phase_len),
    .phase_lanes(phase_lanes), .tx_valid(tx_valid), .tick(sck_tick),
    .last_unit(last_unit), .tx_ready(tx_ready), .ld(ld), .ld_rx(ld_rx),
    .ld_lanes(ld_lanes), .step(step), .busy(busy), .cs_n(cs_n), .done(done)
  );

  qspi_lane_shifter #(.BYTE_W(8), .PINS(4)) shift_i (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_rx(ld_rx), .ld_lanes(ld_lanes),
    .ld_byte(tx_data), .step(step), .flush(done), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .sclk_pulse(sclk_pulse),
    .last_unit(last_unit), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  assert_pulse_in_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_pulse |-> $past(!cs_n));

  assert_stall_no_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> !sclk_pulse);

  assert_read_only_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (w0[DATA_MSB:DATA_LSB] == '0));

endmodule

// File: tb/qspi_phase_seq_tb_top.sv
module qspi_phase_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        sck_tick = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic [3:0]  io_in = '0;
  logic [3:0]  io_out;
  logic [3:0]  io_oe;
  logic        sclk_pulse;
  logic        cs_n;
  logic        busy;

  always #10 clk = ~clk;

  qspi_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .sck_tick(sck_tick), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .sclk_pulse(sclk_pulse), .cs_n(cs_n), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // stream source and monitor state
  logic [7:0] txq [0:63];
  int tx_len, tx_idx;
  bit pop_seen, drive_on, stall_mode;
  int tick_pct = 50;
  logic [7:0] out_bytes [0:63];
  logic [3:0] out_oe    [0:63];
  int out_n, acc_bits;
  logic [7:0] acc;
  logic [3:0] rx_units [0:511];
  int rxu_n;
  logic [7:0] got_rx [0:63];
  int got_n, viol, pops, pulses, busy_cyc, cs_low, starve_n, stall_viol;
  logic [3:0] prev_in = '0;
  logic prev_cs = 1'b1;
  logic prev_starve = 1'b0;
  int mon_ln;

  // expected transaction shape
  int e_cmd, e_addr, e_dum, e_wr, e_rd, e_tx;
  int e_lc, e_la, e_ld;

  function automatic int lanes_of(input logic [1:0] code);
    return (code == 2'd3) ? 4 : (code == 2'd2) ? 2 : 1;
  endfunction

  function automatic logic [3:0] mask_of(input int ln);
    return (ln == 4) ? 4'b1111 : (ln == 2) ? 4'b0011 : 4'b0001;
  endfunction

  function automatic logic [7:0] rx_expect(input int b, input int ln);
    logic [7:0] v;
    int u;
    v = '0;
    u = 8 / ln;
    for (int k = 0; k < u; k++) begin
      logic [3:0] s;
      s = rx_units[b * u + k];
      if (ln == 4)      v = {v[3:0], s};
      else if (ln == 2) v = {v[5:0], s[1:0]};
      else              v = {v[6:0], s[1]};
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cycles++;

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (!cs_n) cs_low++;
    if (sclk_pulse) begin
      pulses++;
      if (prev_cs) viol++;
      if (prev_starve) stall_viol++;
      if (io_oe != 4'b0000) begin
        mon_ln = (io_oe == 4'b1111) ? 4 : (io_oe == 4'b0011) ? 2 : 1;
        for (int l = mon_ln - 1; l >= 0; l--) acc = {acc[6:0], io_out[l]};
        acc_bits += mon_ln;
        if (acc_bits >= 8) begin
          if (out_n < 64) begin
            out_bytes[out_n] = acc;
            out_oe[out_n]    = io_oe;
          end
          out_n++;
          acc_bits = 0;
        end
      end else begin
        if (rxu_n < 512) rx_units[rxu_n] = prev_in;
        rxu_n++;
      end
    end
    if (rx_valid) begin
      if (got_n < 64) got_rx[got_n] = rx_data;
      got_n++;
    end
    if (!cs_n && !busy) viol++;
    if (tx_ready && !tx_valid) starve_n++;
    if (tx_ready && tx_valid) begin
      pops++;
      pop_seen = 1'b1;
    end
    prev_starve = tx_ready && !tx_valid;
    prev_in = io_in;
    prev_cs = cs_n;
  end

  // stream and tick driver, just after the edge
  always @(posedge clk) begin
    #2;
    if (pop_seen) begin
      tx_idx++;
      pop_seen = 1'b0;
    end
    if (drive_on) begin
      tx_valid = (tx_idx < tx_len) && (!stall_mode || ($urandom % 3 != 0));
      tx_data  = (tx_idx < 64) ? txq[tx_idx] : 8'h00;
      sck_tick = ($urandom % 100) < tick_pct;
      if (sck_tick) io_in = 4'($urandom);
    end else begin
      tx_valid = 1'b0;
      sck_tick = 1'b0;
    end
  end

  task automatic write_reg(input logic [1:0] sel, input logic [15:0] val);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic prep(input logic [15:0] c0, input logic [15:0] c1, input logic [15:0] c2,
                      input bit stall);
    out_n = 0; acc_bits = 0; acc = '0; rxu_n = 0; got_n = 0; viol = 0; pops = 0;
    pulses = 0; busy_cyc = 0; cs_low = 0; starve_n = 0; stall_viol = 0;
    e_cmd  = int'(c0[0]);
    e_addr = int'(c0[2:1]) + ((c0[3] && c0[2:1] == 2'd3) ? 1 : 0);
    e_dum  = int'(c1[3:0]);
    e_wr   = int'(c0[14:4]);
    e_rd   = (e_wr != 0) ? 0 : int'(c1[14:4]);
    e_tx   = e_cmd + e_addr + e_dum + e_wr;
    e_lc = lanes_of(c2[1:0]); e_la = lanes_of(c2[3:2]); e_ld = lanes_of(c2[5:4]);
    for (int i = 0; i < 64; i++) txq[i] = 8'($urandom);
    tx_len = e_tx; tx_idx = 0; stall_mode = stall; drive_on = 1'b1;
    write_reg(2'd1, c1);
    write_reg(2'd2, c2);
    write_reg(2'd0, c0 | 16'h8000);
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!busy && n < 50) begin @(posedge clk); n++; end
    n = 0;
    while (busy && n < 20000) begin @(posedge clk); n++; end
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_txn();
    int bad5, bad6, badr, ex;
    logic [3:0] m;
    bad5 = 0; bad6 = 0; badr = 0;
    chk(out_n == e_tx, "R3 bytes shifted out", out_n, e_tx);
    chk(pops == e_tx, "R3 bytes popped from stream", pops, e_tx);
    for (int i = 0; i < out_n && i < 64; i++) begin
      if (out_bytes[i] !== txq[i]) bad6++;
      if (i < e_cmd) m = mask_of(e_lc);
      else if (i < e_cmd + e_addr + e_dum) m = mask_of(e_la);
      else m = mask_of(e_ld);
      if (out_oe[i] !== m) bad5++;
    end
    chk(bad6 == 0, "R6 MSB-first byte content", bad6, 0);
    chk(bad5 == 0, "R5 per-phase lane mask", bad5, 0);
    ex = e_tx * 0;
    for (int i = 0; i < e_cmd; i++) ex += 8 / e_lc;
    for (int i = 0; i < e_addr + e_dum; i++) ex += 8 / e_la;
    for (int i = 0; i < e_wr + e_rd; i++) ex += 8 / e_ld;
    chk(pulses == ex, "R5 clocks per byte", pulses, ex);
    chk(got_n == e_rd, "R7 read bytes pushed", got_n, e_rd);
    for (int b = 0; b < got_n && b < 64; b++)
      if (got_rx[b] !== rx_expect(b, e_ld)) badr++;
    chk(badr == 0, "R7 read byte assembly", badr, 0);
    chk(viol == 0, "R9 select framing", viol, 0);
    busy_cyc = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(busy_cyc == 0, "R9 valid self-clears, no restart", busy_cyc, 0);
  endtask

  initial begin
    logic [15:0] c0, c1, c2;
    void'($urandom(32'h5eed_0417));
    drive_on = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && busy == 1'b0, "R1 cs_n/busy at reset", {cs_n, busy}, 2);
    chk(io_oe == 4'b0 && sclk_pulse == 1'b0 && rx_valid == 1'b0 && tx_ready == 1'b0,
        "R1 outputs quiet at reset", io_oe, 0);
    @(posedge clk); #2 rst_n = 1'b1;

    // R2: valid without enable stays idle, then enable starts it
    prep({1'b0, 11'd2, 1'b0, 2'd2, 1'b1}, 16'h0001, 16'h0015, 1'b0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(busy_cyc == 0 && pops == 0, "R2 idle while ctrl_en low", busy_cyc + pops, 0);
    @(posedge clk); #2 ctrl_en = 1'b1;
    wait_done();
    chk(out_n == 6, "R2 starts once enabled", out_n, 6);
    check_txn();

    // R4: four address bytes with flag and count 3
    prep({1'b0, 11'd0, 1'b1, 2'd3, 1'b1}, {1'b0, 11'd3, 4'd0}, 16'h0035, 1'b0);
    wait_done();
    chk(out_n == 5, "R4 four-byte address", out_n, 5);
    check_txn();
    // R4: flag ignored with count 2
    prep({1'b0, 11'd0, 1'b1, 2'd2, 1'b1}, {1'b0, 11'd0, 4'd0}, 16'h0015, 1'b0);
    wait_done();
    chk(out_n == 3, "R4 flag no effect below count 3", out_n, 3);
    check_txn();

    // R7: quad read with dummy on dual address width
    prep({1'b0, 11'd0, 1'b0, 2'd3, 1'b1}, {1'b0, 11'd12, 4'd2}, 16'h0039, 1'b0);
    wait_done();
    check_txn();

    // R8: both write and read counts set
    prep({1'b0, 11'd4, 1'b0, 2'd1, 1'b1}, {1'b0, 11'd5, 4'd0}, 16'h0025, 1'b0);
    wait_done();
    chk(got_n == 0, "R8 read ignored when writing", got_n, 0);
    check_txn();

    // R11: all counts zero
    prep(16'h0000, 16'h0000, 16'h0000, 1'b0);
    wait_done();
    chk(busy_cyc >= 1, "R11 busy raised for empty run", busy_cyc, 1);
    chk(pulses == 0 && cs_low == 0, "R11 no clock, select untouched", pulses + cs_low, 0);
    check_txn();

    // R10: quad write with stream gaps
    prep({1'b0, 11'd16, 1'b0, 2'd3, 1'b1}, 16'h0000, 16'h003F, 1'b1);
    wait_done();
    chk(starve_n > 0, "R10 stream gaps occurred", starve_n, 1);
    chk(stall_viol == 0, "R10 no clock while starved", stall_viol, 0);
    check_txn();

    // random mix
    for (int t = 0; t < 24; t++) begin
      c0 = {1'b0, ($urandom % 2 == 0) ? 11'd0 : 11'($urandom % 17), 1'($urandom),
            2'($urandom), 1'($urandom)};
      c1 = {1'b0, 11'($urandom % 17), 4'($urandom % 5)};
      c2 = {10'd0, 6'($urandom)};
      prep(c0, c1, c2, 1'($urandom % 4 == 0));
      wait_done();
      check_txn();
    end

    drive_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule